// File: doc/BRIEF.md
# Staged Power-Domain Switch Sequencer

This block sequences the header switches and the isolation barrier of one switchable logic domain. A bank of parallel power switches feeds the domain. Each switch has one control bit, where 1 means the switch is open (off) and 0 means it is closed (on). An isolation-enable output clamps the domain's outputs while the domain is unpowered or only partly powered.

- **Powering down:** the sequencer raises isolation first. On the next step it opens every switch at once.
- **Powering up:** it closes the switches one at a time. It holds each intermediate pattern for a programmed number of cycles so that inrush current stays limited.
- **Releasing isolation:** this is a separate final step. It happens only after the last switch has closed and the last wait has run out.

A power controller drives the two request inputs. It watches `busy` and the one-cycle `done` pulse to learn when a transition has finished. The order in which switches close is set by a parameter. The linear order walks from the top bit down. The two-group order empties the lower half of the bus from its top bit down, then the upper half from its top bit down.

Top module: `pdsw_sequencer`

## Requirements
- R1: After reset, every bit of `sw_off` is 1, `iso_en` is 1, and both `busy` and `done` are 0.
- R2: With the domain on, a `req_off` sampled at a clock edge raises `iso_en` on that edge while every switch stays closed. On the following edge, all `sw_off` bits go to 1 together.
- R3: With the domain off, a `req_on` sampled at an edge starts power-up on that same edge. Each step closes exactly one switch. In the linear order the bus reads 0x7F, 0x3F, 0x1F, 0x0F, 0x07, 0x03, 0x01, 0x00 for eight switches.
- R4: Every switch pattern produced during power-up, including the final all-closed pattern, is held for exactly `WAIT_CYC` cycles before the next step. The step timer reloads at every switch transition.
- R5: `iso_en` falls only when all `sw_off` bits are 0. It falls on the edge that ends the wait after the final switch closed, and never earlier.
- R6: `busy` is 1 from the edge that starts a sequence until the edge that completes it, and 0 otherwise. A request of the opposite direction that arrives while `busy` is 1 is ignored.
- R7: `done` is a single-cycle pulse on the completing edge of either sequence. Power-up completes when isolation is released; power-down completes when all switches are open.
- R8: With `GROUPED` = 1, power-up clears the lower half of the bus from its top bit down, then the upper half from its top bit down. For eight switches this gives 0xF7, 0xF3, 0xF1, 0xF0, 0x70, 0x30, 0x10, 0x00.
- R9: A `req_on` while the domain is fully on, and a `req_off` while it is fully off, leave `sw_off`, `iso_en`, `busy` and `done` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_on | input | 1 | Request to power the domain up |
| req_off | input | 1 | Request to power the domain down |
| sw_off | output | N_SW | Switch controls, one bit per switch, 1 = open |
| iso_en | output | 1 | Isolation barrier enable, 1 = isolated |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence completes |

## Verification
On every cycle, the assertions check four things:
- isolation is never released while any switch is open;
- a power-down request raises isolation before any switch opens;
- the switch pattern is stable between steps, and each step drops exactly one open bit;
- `done` is a lone pulse that never coincides with `busy`.

The exact step order of both ordering variants, the cycle count between steps, and the edge on which isolation falls can only be shown by the bench's scenarios. The same holds for ignoring opposite requests in mid-sequence and ignoring redundant requests, since these compare the ports against values computed from the requirements.

// File: rtl/pdsw_pkg.sv
package pdsw_pkg;

  typedef enum logic [1:0] {
    PD_OFF  = 2'd0,
    PD_RAMP = 2'd1,
    PD_ON   = 2'd2,
    PD_ISOL = 2'd3
  } pd_state_t;

endpackage

// File: rtl/pdsw_wait_timer.sv
module pdsw_wait_timer #(
  parameter int WAIT_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int CW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(WAIT_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? RELOAD : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/pdsw_step_order.sv
module pdsw_step_order #(
  parameter int N_SW    = 8,
  parameter bit GROUPED = 1'b0,
  parameter int STEP_W  = 4
) (
  input  logic [STEP_W-1:0] step,
  output logic [N_SW-1:0]   close_mask
);
  localparam int HALF = N_SW / 2;

  int target;

  generate
    if (GROUPED) begin : g_two_groups
      always_comb begin
        if (int'(step) < HALF) target = HALF - 1 - int'(step);
        else                   target = N_SW - 1 - (int'(step) - HALF);
      end
    end else begin : g_linear
      always_comb target = N_SW - 1 - int'(step);
    end
  endgenerate

  always_comb begin
    for (int b = 0; b < N_SW; b++) close_mask[b] = (b == target);
  end
endmodule

// File: rtl/pdsw_sequencer.sv
module pdsw_sequencer
  import pdsw_pkg::*;
#(
  parameter int N_SW     = 8,
  parameter int WAIT_CYC = 16,
  parameter bit GROUPED  = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_on,
  input  logic            req_off,
  output logic [N_SW-1:0] sw_off,
  output logic            iso_en,
  output logic            busy,
  output logic            done
);
  localparam int STEP_W = $clog2(N_SW + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_SW);

  // reset synchronizer: asynchronous assertion, synchronous release
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  pd_state_t         state_q, state_d;
  logic [N_SW-1:0]   sw_q, sw_d;
  logic              iso_q, iso_d;
  logic              done_q, done_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              tmr_load, tmr_exp;
  logic [N_SW-1:0]   close_mask;
  logic [STEP_W-1:0] order_idx;

  pdsw_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (tmr_load),
    .expired (tmr_exp)
  );

  assign order_idx = (state_q == PD_OFF) ? '0 : step_q;

  pdsw_step_order #(.N_SW(N_SW), .GROUPED(GROUPED), .STEP_W(STEP_W)) u_order (
    .step       (order_idx),
    .close_mask (close_mask)
  );

  always_comb begin
    state_d  = state_q;
    sw_d     = sw_q;
    iso_d    = iso_q;
    step_d   = step_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    unique case (state_q)
      PD_OFF: if (req_on) begin
        sw_d     = sw_q & ~close_mask;
        step_d   = STEP_W'(1);
        tmr_load = 1'b1;
        state_d  = PD_RAMP;
      end
      PD_RAMP: if (tmr_exp) begin
        if (step_q == LAST_STEP) begin
          iso_d   = 1'b0;
          done_d  = 1'b1;
          state_d = PD_ON;
        end else begin
          sw_d     = sw_q & ~close_mask;
          step_d   = step_q + 1'b1;
          tmr_load = 1'b1;
        end
      end
      PD_ON: if (req_off) begin
        iso_d   = 1'b1;
        state_d = PD_ISOL;
      end
      PD_ISOL: begin
        sw_d    = '1;
        done_d  = 1'b1;
        state_d = PD_OFF;
      end
      default: state_d = PD_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= PD_OFF;
      sw_q    <= '1;
      iso_q   <= 1'b1;
      done_q  <= 1'b0;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      sw_q    <= sw_d;
      iso_q   <= iso_d;
      done_q  <= done_d;
      step_q  <= step_d;
    end
  end

  assign sw_off = sw_q;
  assign iso_en = iso_q;
  assign done   = done_q;
  assign busy   = (state_q == PD_RAMP) || (state_q == PD_ISOL);

  // R5: isolation may be down only with every switch closed
  assert_iso_release_all_closed_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !iso_en |-> (sw_off == '0));

  // R2: a power-down raises isolation before any switch opens
  assert_isolate_before_open_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == PD_ON && req_off) |=> (iso_en && sw_off == '0));

  // R4: switch pattern frozen while the step timer is running
  assert_hold_between_steps_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == PD_RAMP && !tmr_exp) |=> $stable(sw_off));

  // R3: each ramp step closes exactly one switch
  assert_one_switch_per_step_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == PD_RAMP && tmr_exp && step_q != LAST_STEP)
      |=> ($countones(sw_off) + 1 == $countones($past(sw_off))));

  // R7: done never lasts more than one cycle
  assert_done_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done);

  // R6: done marks the end of busy, never overlaps it
  assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> !busy);
endmodule

// File: tb/tb_pdsw_sequencer.sv
`timescale 1ns/1ps
module tb_pdsw_sequencer;
  localparam int N  = 8;
  localparam int WA = 5;
  localparam int WB = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic on_a = 1'b0, off_a = 1'b0, on_b = 1'b0, off_b = 1'b0;
  logic [N-1:0] sw_a, sw_b;
  logic iso_a, iso_b, busy_a, busy_b, done_a, done_b;
  int errors = 0, checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pdsw_sequencer #(.N_SW(N), .WAIT_CYC(WA), .GROUPED(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .req_on(on_a), .req_off(off_a),
    .sw_off(sw_a), .iso_en(iso_a), .busy(busy_a), .done(done_a));

  pdsw_sequencer #(.N_SW(N), .WAIT_CYC(WB), .GROUPED(1'b1)) dut_grp (
    .clk(clk), .rst_n(rst_n), .req_on(on_b), .req_off(off_b),
    .sw_off(sw_b), .iso_en(iso_b), .busy(busy_b), .done(done_b));

  function automatic logic [N-1:0] g_sw(bit g); return g ? sw_b : sw_a; endfunction
  function automatic logic g_iso(bit g);  return g ? iso_b : iso_a; endfunction
  function automatic logic g_busy(bit g); return g ? busy_b : busy_a; endfunction
  function automatic logic g_done(bit g); return g ? done_b : done_a; endfunction

  function automatic logic [N-1:0] exp_step(bit g, int i);
    logic [3:0] lo, hi;
    if (!g) return 8'hFF >> (i + 1);
    lo = (i < 4) ? (4'hF >> (i + 1)) : 4'h0;
    hi = (i < 4) ? 4'hF : (4'hF >> (i - 3));
    return {hi, lo};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(bit g, bit on, bit off);
    if (g) begin on_b = on; off_b = off; end
    else   begin on_a = on; off_a = off; end
  endtask

  task automatic t_reset_state();
    check("R1", "sw_off", sw_a, 8'hFF);
    check("R1", "iso_en", iso_a, 1);
    check("R1", "busy", busy_a, 0);
    check("R1", "done", done_a, 0);
    check("R1", "grp sw_off", sw_b, 8'hFF);
  endtask

  task automatic t_off_when_off();
    @(negedge clk); drive(0, 0, 1);
    @(negedge clk); drive(0, 0, 0);
    for (int k = 0; k < 3; k++) begin
      check("R9", "sw_off stays open", sw_a, 8'hFF);
      check("R9", "busy stays low", busy_a, 0);
      check("R9", "no done", done_a, 0);
      @(negedge clk);
    end
  endtask

  // power-up; poke=1 injects an off request mid-ramp
  task automatic t_power_on(bit g, int w, bit poke);
    string rq = g ? "R8" : "R3";
    @(negedge clk); drive(g, 1, 0);
    @(negedge clk); drive(g, 0, 0);
    for (int i = 0; i < N; i++) begin
      check(rq, $sformatf("step %0d pattern", i), g_sw(g), exp_step(g, i));
      check("R6", "busy during ramp", g_busy(g), 1);
      check("R5", "iso held during ramp", g_iso(g), 1);
      for (int k = 0; k < w - 1; k++) begin
        if (poke && i == 2 && k == 0) drive(g, 0, 1);
        @(negedge clk);
        if (poke && i == 2 && k == 0) drive(g, 0, 0);
      end
      check("R4", $sformatf("step %0d held", i), g_sw(g), exp_step(g, i));
      check("R5", "iso before final wait ends", g_iso(g), 1);
      @(negedge clk);
    end
    check("R5", "iso released", g_iso(g), 0);
    check("R5", "all closed", g_sw(g), '0);
    check("R7", "done on release", g_done(g), 1);
    check("R6", "busy cleared", g_busy(g), 0);
    @(negedge clk);
    check("R7", "done single cycle", g_done(g), 0);
  endtask

  // power-down; poke=1 holds an on request across the whole sequence
  task automatic t_power_off(bit g, bit poke);
    @(negedge clk); drive(g, poke, 1);
    @(negedge clk); drive(g, poke, 0);
    check("R2", "iso raised first", g_iso(g), 1);
    check("R2", "switches still closed", g_sw(g), '0);
    check("R6", "busy while isolating", g_busy(g), 1);
    @(negedge clk); drive(g, 0, 0);
    check("R2", "all switches open", g_sw(g), 8'hFF);
    check("R7", "done on open", g_done(g), 1);
    check("R6", "busy cleared", g_busy(g), 0);
    @(negedge clk);
    check("R7", "done single cycle", g_done(g), 0);
    for (int k = 0; k < 3; k++) begin
      check("R6", "on request during off ignored", g_sw(g), 8'hFF);
      check("R6", "no restart", g_busy(g), 0);
      @(negedge clk);
    end
  endtask

  task automatic t_on_when_on();
    @(negedge clk); drive(0, 1, 0);
    @(negedge clk); drive(0, 0, 0);
    for (int k = 0; k < 3; k++) begin
      check("R9", "sw_off stays closed", sw_a, 8'h00);
      check("R9", "iso stays off", iso_a, 0);
      check("R9", "busy stays low", busy_a, 0);
      check("R9", "no done", done_a, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_off_when_off();
    t_power_on(0, WA, 0);
    t_on_when_on();
    t_power_off(0, 0);
    t_power_on(0, WA, 1);
    t_power_off(0, 1);
    t_power_on(1, WB, 0);
    t_power_off(1, 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule